// File: doc/BRIEF.md
# MAC Path Stop and Soft-Reset Controller

This block is the control and status register slice for the transmit and receive paths of an Ethernet-style MAC. Software uses it to take a path down cleanly: it clears the path's enable, polls a read-only state register until the path reads idle, and then requests a software reset. The reset request bits stay set while the internal reset runs and clear themselves when it is over, so software can poll them to learn when the path is ready to be configured again.

Each direction is represented by a small frame-activity model. A start pulse begins a frame when the path is enabled and idle, and the frame occupies the path for its requested length, clipped to a programmable maximum frame size. A disabled path finishes the frame it is carrying but takes no new one. A reset request aborts any frame at once. Software reaches all registers through a simple word-addressed read/write port with one cycle of read latency.

Top module: `mac_stop_rst_ctl`

## Requirements
- R1: After reset the control word, the state word and both reset words read 0 and the frame size limit reads 0x05EE.
- R2: The control word at offset 0x00 holds the transmit enable at bit 0 and the receive enable at bit 8; all other bits read 0 whatever was written.
- R3: An enabled, idle path given a start pulse is busy for exactly min(length, limit) cycles, with a length or limit of 0 counting as 1; the state word at offset 0x04 shows the transmit engine in bits 2:0 (0 idle, 1 active, 2 draining) and receive busy in bit 7.
- R4: A start pulse on a path whose enable is 0 is ignored and the path stays idle.
- R5: Clearing an enable mid-frame lets that frame run to its full length with the transmit state reading 2, after which the path reads idle and takes no new frame.
- R6: The frame size limit at offset 0x10, bits 13:0, is writable and accepts 0x3FFF for jumbo frames.
- R7: Writing 1 to bit 0 (soft reset) or bit 1 (register reset) of the transmit reset word (offset 0x08) or receive reset word (offset 0x0C) sets those bits; they read back as set for 16 cycles and then clear to 0 by themselves.
- R8: Writing 0 to the reset bits has no effect: nothing is reset and a frame in progress continues.
- R9: A reset request on a busy path forces its engine idle in the cycle after the write, aborting the frame.
- R10: A register reset on either direction clears the whole control word, both enables included; a soft reset alone leaves the control word unchanged.
- R11: Writes to the state word are ignored, reads return data one cycle after the request, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| tx_start_i | input | 1 | Transmit frame start pulse |
| tx_len_i | input | LEN_W | Transmit frame length in cycles |
| rx_start_i | input | 1 | Receive frame start pulse |
| rx_len_i | input | LEN_W | Receive frame length in cycles |
| tx_busy_o | output | 1 | Transmit engine not idle |
| rx_busy_o | output | 1 | Receive engine not idle |

## Verification
The frame engine is driven from a vector table of lengths and limits on both directions: lengths below, equal to and above the limit tell clipping apart from pass-through, and zero length checks the minimum of one cycle. Directed sequences then separate the stop patterns: a start while disabled, an enable cleared mid-frame (drain to full length against early cut-off), and a reset during a frame (abort against completion). Reset words are read on the exact cycles before and after the self-clear to pin the 16-cycle window, and register against soft reset is told apart by reading the control word afterwards.

// File: rtl/mac_ctl_pkg.sv
package mac_ctl_pkg;
  localparam int DATA_W = 32;
  localparam int NDIR   = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  localparam int OFS_CFG    = 'h00;
  localparam int OFS_STATE  = 'h04;
  localparam int OFS_TX_RST = 'h08;
  localparam int OFS_RX_RST = 'h0C;
  localparam int OFS_MAXLEN = 'h10;

  localparam int CFG_TX_EN_BIT     = 0;
  localparam int CFG_RX_EN_BIT     = 8;
  localparam int STATE_RX_BUSY_BIT = 7;
  localparam int RST_SOFT_BIT      = 0;
  localparam int RST_REG_BIT       = 1;

  typedef enum logic [2:0] {
    ENG_IDLE   = 3'd0,
    ENG_ACTIVE = 3'd1,
    ENG_DRAIN  = 3'd2
  } eng_state_e;
endpackage

// File: rtl/mac_frame_engine.sv
module mac_frame_engine
  import mac_ctl_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] max_len_i,
  output eng_state_e       state_o,
  output logic             busy_o
);
  eng_state_e       st;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_clip;

  always_comb begin
    len_clip = (len_i > max_len_i) ? max_len_i : len_i;
    if (len_clip == '0) len_clip = LEN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= ENG_IDLE;
      cnt <= '0;
    end else if (abort_i) begin
      st  <= ENG_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ENG_IDLE: begin
          if (en_i && start_i) begin
            st  <= ENG_ACTIVE;
            cnt <= len_clip - LEN_W'(1);
          end
        end
        ENG_ACTIVE, ENG_DRAIN: begin
          if (cnt == '0) begin
            st <= ENG_IDLE;
          end else begin
            cnt <= cnt - LEN_W'(1);
            st  <= en_i ? ENG_ACTIVE : ENG_DRAIN;  // finish frame, flag drain
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign state_o = st;
  assign busy_o  = (st != ENG_IDLE);
endmodule

// File: rtl/mac_rst_seq.sv
module mac_rst_seq #(
  parameter int CYCLES = 16,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] set_i,
  output logic [1:0] bits_o
);
  logic [1:0]       bits;
  logic [CNT_W-1:0] cnt;
  logic             done;

  assign done = (bits != 2'b00) && (cnt == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits <= 2'b00;
      cnt  <= '0;
    end else if (done) begin
      bits <= set_i;
      cnt  <= '0;
    end else if (bits != 2'b00) begin
      bits <= bits | set_i;  // late requests merge into the running reset
      cnt  <= cnt + CNT_W'(1);
    end else begin
      bits <= set_i;
      cnt  <= '0;
    end
  end

  assign bits_o = bits;
endmodule

// File: rtl/mac_stop_rst_ctl.sv
module mac_stop_rst_ctl
  import mac_ctl_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          LEN_W       = 14,
  parameter int          RST_CYCLES  = 16,
  parameter logic [13:0] MAX_LEN_RST = 14'h05EE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tx_start_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic              rx_start_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  output logic              tx_busy_o,
  output logic              rx_busy_o
);
  logic [NDIR-1:0]            cfg_en;
  logic [LEN_W-1:0]           max_len;
  logic [NDIR-1:0][1:0]       rst_set;
  logic [NDIR-1:0][1:0]       rst_bits;
  logic [NDIR-1:0]            abort;
  logic [NDIR-1:0]            eng_busy;
  logic [NDIR-1:0]            start_vec;
  logic [NDIR-1:0][LEN_W-1:0] len_vec;
  eng_state_e                 eng_st [NDIR];
  logic                       wr_cfg, wr_maxlen, reg_clear;
  logic [DATA_W-1:0]          rd_val;

  assign start_vec = {rx_start_i, tx_start_i};
  assign len_vec   = {rx_len_i, tx_len_i};
  assign wr_cfg    = wr_en_i && (addr_i == ADDR_W'(OFS_CFG));
  assign wr_maxlen = wr_en_i && (addr_i == ADDR_W'(OFS_MAXLEN));
  assign reg_clear = rst_set[DIR_TX][RST_REG_BIT]  | rst_set[DIR_RX][RST_REG_BIT] |
                     rst_bits[DIR_TX][RST_REG_BIT] | rst_bits[DIR_RX][RST_REG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_en  <= '0;
      max_len <= LEN_W'(MAX_LEN_RST);
    end else begin
      if (reg_clear)   cfg_en <= '0;
      else if (wr_cfg) cfg_en <= {wdata_i[CFG_RX_EN_BIT], wdata_i[CFG_TX_EN_BIT]};
      if (wr_maxlen)   max_len <= wdata_i[LEN_W-1:0];
    end
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam int RST_OFS = (d == DIR_TX) ? OFS_TX_RST : OFS_RX_RST;
    logic wr_rst;

    assign wr_rst     = wr_en_i && (addr_i == ADDR_W'(RST_OFS));
    assign rst_set[d] = wr_rst ? wdata_i[1:0] : 2'b00;
    // request aborts on the write edge itself, held while the reset runs
    assign abort[d]   = (|rst_set[d]) || (|rst_bits[d]);

    mac_rst_seq #(.CYCLES(RST_CYCLES)) u_rst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (rst_set[d]),
      .bits_o (rst_bits[d])
    );

    mac_frame_engine #(.LEN_W(LEN_W)) u_eng (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (cfg_en[d]),
      .abort_i   (abort[d]),
      .start_i   (start_vec[d]),
      .len_i     (len_vec[d]),
      .max_len_i (max_len),
      .state_o   (eng_st[d]),
      .busy_o    (eng_busy[d])
    );
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_W'(OFS_CFG)) begin
      rd_val[CFG_TX_EN_BIT] = cfg_en[DIR_TX];
      rd_val[CFG_RX_EN_BIT] = cfg_en[DIR_RX];
    end else if (addr_i == ADDR_W'(OFS_STATE)) begin
      rd_val[2:0]               = eng_st[DIR_TX];
      rd_val[STATE_RX_BUSY_BIT] = eng_busy[DIR_RX];
    end else if (addr_i == ADDR_W'(OFS_TX_RST)) begin
      rd_val[1:0] = rst_bits[DIR_TX];
    end else if (addr_i == ADDR_W'(OFS_RX_RST)) begin
      rd_val[1:0] = rst_bits[DIR_RX];
    end else if (addr_i == ADDR_W'(OFS_MAXLEN)) begin
      rd_val[LEN_W-1:0] = max_len;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assign tx_busy_o = eng_busy[DIR_TX];
  assign rx_busy_o = eng_busy[DIR_RX];

  logic unused_bits;
  assign unused_bits = ^{wdata_i, eng_st[DIR_RX]};
endmodule

// File: rtl/mac_stop_rst_chk.sv
module mac_stop_rst_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      cfg_en_i,
  input logic [1:0]      busy_i,
  input logic [1:0]      abort_i,
  input logic [1:0][1:0] rst_set_i,
  input logic [1:0][1:0] rst_bits_i
);
  for (genvar d = 0; d < 2; d++) begin : g_chk
    logic [15:0] run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 run <= '0;
      else if (|rst_set_i[d])      run <= 16'd1;
      else if (|rst_bits_i[d])     run <= run + 16'd1;
      else                         run <= '0;
    end

    assert_no_start_when_disabled_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_en_i[d] && !busy_i[d]) |=> !busy_i[d]);

    assert_abort_on_reset_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_i[d] |=> !busy_i[d]);

    assert_rst_self_clear_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|rst_bits_i[d]) |-> (run <= 16'(RST_CYCLES)));

    assert_reg_rst_clears_cfg_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_bits_i[d][1] |=> (cfg_en_i == 2'b00));
  end
endmodule

bind mac_stop_rst_ctl mac_stop_rst_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_en_i   (cfg_en),
  .busy_i     (eng_busy),
  .abort_i    (abort),
  .rst_set_i  (rst_set),
  .rst_bits_i (rst_bits)
);

// File: tb/tb_mac_stop_rst_ctl.sv
`timescale 1ns/1ps
module tb_mac_stop_rst_ctl;
  localparam logic [7:0] A_CFG = 8'h00, A_ST = 8'h04, A_TXR = 8'h08,
                         A_RXR = 8'h0C, A_MAX = 8'h10, A_NONE = 8'h1C;
  localparam int NV = 6;
  localparam logic [13:0] V_LEN [NV] = '{14'd5, 14'd1, 14'd0, 14'd40, 14'd3, 14'd100};
  localparam logic [13:0] V_MAX [NV] = '{14'd1518, 14'd1518, 14'd1518, 14'd20, 14'd3, 14'h3FFF};
  localparam int          V_EXP [NV] = '{5, 1, 1, 20, 3, 100};

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic tx_start = 0, rx_start = 0;
  logic [13:0] tx_len = '0, rx_len = '0;
  logic tx_busy, rx_busy;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mac_stop_rst_ctl dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tx_start_i(tx_start), .tx_len_i(tx_len),
    .rx_start_i(rx_start), .rx_len_i(rx_len),
    .tx_busy_o(tx_busy), .rx_busy_o(rx_busy)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic pulse(input int dir, input logic [13:0] len);
    if (dir == 0) begin tx_start = 1; tx_len = len; end
    else          begin rx_start = 1; rx_len = len; end
    @(negedge clk);
    tx_start = 0; rx_start = 0;
  endtask

  function automatic logic busy_of(input int dir);
    return (dir == 0) ? tx_busy : rx_busy;
  endfunction

  task automatic wait_idle(input int dir, input int t0, output int elapsed);
    for (int g = 0; g < 20000 && busy_of(dir); g++) @(negedge clk);
    elapsed = cyc - t0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t0, el;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_CFG, d); chk("R1 cfg", d, 32'h0);
    rd(A_ST, d);  chk("R1 state", d, 32'h0);
    rd(A_TXR, d); chk("R1 tx rst", d, 32'h0);
    rd(A_RXR, d); chk("R1 rx rst", d, 32'h0);
    rd(A_MAX, d); chk("R1 max len", d, 32'h05EE);

    // R2 control word fields
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, d); chk("R2 cfg all ones", d, 32'h101);
    wr(A_CFG, 32'h0000_0100); rd(A_CFG, d); chk("R2 cfg rx only", d, 32'h100);

    // R4 disabled paths ignore starts
    pulse(0, 14'd5); chk("R4 tx disabled", tx_busy, 1'b0);
    wr(A_CFG, 32'h0);
    pulse(1, 14'd5); chk("R4 rx disabled", rx_busy, 1'b0);

    // R3 R6 vector table
    wr(A_CFG, 32'h101);
    for (int dir = 0; dir < 2; dir++) begin
      for (int i = 0; i < NV; i++) begin
        wr(A_MAX, {18'h0, V_MAX[i]});
        pulse(dir, V_LEN[i]);
        t0 = cyc;
        wait_idle(dir, t0, el);
        chk($sformatf("R3 dir%0d vec%0d busy cycles", dir, i), el, V_EXP[i]);
      end
    end
    rd(A_MAX, d); chk("R6 jumbo limit readback", d, 32'h3FFF);

    // R3 state word encoding
    pulse(0, 14'd20);
    rd(A_ST, d); chk("R3 tx active", d, 32'h01);
    pulse(1, 14'd20);
    rd(A_ST, d); chk("R3 tx active rx busy", d, 32'h81);
    wait_idle(0, cyc, el); wait_idle(1, cyc, el);
    rd(A_ST, d); chk("R3 both idle", d, 32'h0);

    // R5 drain after disable
    pulse(0, 14'd20);
    t0 = cyc;
    wr(A_CFG, 32'h100);
    @(negedge clk);
    rd(A_ST, d); chk("R5 tx draining", d, 32'h02);
    wait_idle(0, t0, el); chk("R5 frame runs full length", el, 20);
    pulse(0, 14'd5); chk("R5 no new frame after stop", tx_busy, 1'b0);

    // R11 read-only state, unmapped
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R11 state write ignored", d, 32'h0);
    rd(A_NONE, d); chk("R11 unmapped reads zero", d, 32'h0);

    // R9 abort, R10 soft reset keeps cfg
    wr(A_CFG, 32'h101);
    pulse(1, 14'd50); chk("R9 rx busy before reset", rx_busy, 1'b1);
    wr(A_RXR, 32'h1); chk("R9 rx aborted", rx_busy, 1'b0);
    rd(A_RXR, d); chk("R7 rx soft bit set", d, 32'h1);
    rd(A_CFG, d); chk("R10 soft reset keeps cfg", d, 32'h101);
    repeat (20) @(negedge clk);
    rd(A_RXR, d); chk("R7 rx bit self-cleared", d, 32'h0);

    // R8 zero writes
    pulse(0, 14'd30);
    wr(A_TXR, 32'h0); chk("R8 frame continues", tx_busy, 1'b1);
    rd(A_TXR, d); chk("R8 tx rst still zero", d, 32'h0);
    wait_idle(0, cyc, el);

    // R7 exact window, R10 register reset
    wr(A_TXR, 32'h3);
    repeat (15) @(negedge clk);
    rd(A_TXR, d); chk("R7 bits held through 16th cycle", d, 32'h3);
    rd(A_TXR, d); chk("R7 bits cleared after 16 cycles", d, 32'h0);
    rd(A_CFG, d); chk("R10 register reset clears cfg", d, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule